// File: doc/BRIEF.md
# Two-Channel Positioned Audio Serializer

This block moves audio samples between 32-bit FIFO words and the serial data lines of a framed audio port, for two channels in each frame. The frame timing lives outside: it supplies a count of the current bit within the frame and a one-cycle strobe for each bit clock. For each direction, every channel has its own descriptor with an enable, an absolute start bit and a sample width. A channel's MSB goes out, or is captured, on the bit whose count equals the start bit. The remaining bits follow MSB first, one per strobe.

Transmit takes one FIFO word per enabled channel. In packed mode it takes one word for both channels, each carrying 16 bits. Receive builds right-aligned samples and pushes them as whole words, or pairs them into one packed word. A transmit FIFO that runs dry sends zeros and raises an underrun strobe. A full receive FIFO loses the sample and raises an overrun strobe. For I2S-style or early-sync timing, software adds the one-bit data delay to the start bit. Capturing at bit 0 is only dependable when this side drives the frame sync.

Top module: `dual_slot_serdes`

## Requirements
- R1: During and right after reset, txOut is 0 and txPop, rxPush, txUnderrun and rxOverrun are all low.
- R2: Each 32-bit descriptor word places channel 1 in bits 31:16 and channel 2 in bits 15:0. Within a half, bit 15 is the width extension, bit 14 is the enable, bits 13:4 are the start bit and bits 3:0 are the width code.
- R3: Sample width is 8 plus the width code, plus 16 when the extension bit is set. Widths above 32 are treated as 32, so code 0 with extension gives 24 bits and code 15 with extension gives 32.
- R4: On the strobe whose bit count equals a transmit channel's start bit, txOut takes the sample's MSB. Each later strobe sends the next lower bit. txOut changes in the cycle after a strobe cycle and holds between strobes.
- R5: On a strobe outside every enabled transmit window, txOut becomes 0.
- R6: Without packing, each enabled transmit channel pops one FIFO word at its start strobe. txPop is high during that strobe cycle, and only while txValid is high.
- R7: With transmit packing, channel 1's start strobe pops one word. Channel 1 sends bits 15:0 and channel 2 sends bits 31:16. If channel 1 is disabled, channel 2 pops its own word and sends its bits 31:16.
- R8: A pop with txValid low sends an all-zero sample, and txUnderrun pulses for one cycle after that strobe cycle.
- R9: Without packing, each enabled receive channel samples rxIn on the strobes of its window, MSB first. The right-aligned, zero-extended sample appears on rxWord with a one-cycle rxPush in the cycle after its last strobe.
- R10: With receive packing, one word is pushed when channel 2 completes, holding channel 2 in bits 31:16 and channel 1 in bits 15:0. A disabled channel contributes zeros. With channel 2 disabled, the push happens when channel 1 completes.
- R11: A push that meets rxFull high is dropped: rxPush stays low and rxOverrun pulses for one cycle instead.
- R12: A disabled channel pops nothing, pushes nothing and adds nothing to txOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle strobe per bit clock |
| bitPos | input | 10 | Bit count within the frame for the current strobe |
| txCfg | input | 32 | Transmit channel descriptors |
| rxCfg | input | 32 | Receive channel descriptors |
| txPacked | input | 1 | Transmit packing, two 16-bit samples per word |
| rxPacked | input | 1 | Receive packing, two 16-bit samples per word |
| txWord | input | 32 | Head word of the transmit FIFO |
| txValid | input | 1 | Transmit FIFO holds a word |
| txPop | output | 1 | Take the head word from the transmit FIFO |
| txUnderrun | output | 1 | Pulse: a pop found the transmit FIFO empty |
| txOut | output | 1 | Serial transmit data |
| rxIn | input | 1 | Serial receive data |
| rxWord | output | 32 | Word to store in the receive FIFO |
| rxPush | output | 1 | Store rxWord |
| rxFull | input | 1 | Receive FIFO cannot accept a word |
| rxOverrun | output | 1 | Pulse: a receive word was dropped |

## Verification
txPop depends only on inputs, so it is due during the strobe cycle itself. txOut, rxPush, rxWord, txUnderrun and rxOverrun each pass through one register, so they are due in the cycle after the strobe. The bench raises each strobe on a falling edge and samples outputs 1 ns after the next rising edge, while the strobe is still high. At that moment it compares txOut with the next queued expected bit, takes any pop from its FIFO model, and checks any push against the queued expected word. Pop, underrun and overrun totals for each frame are compared after the frame's last strobe has drained.

// File: rtl/serdes_pkg.sv
package serdes_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int POS_W  = 10;
  localparam int CODE_W = 4;
  localparam int CNT_W  = $clog2(WORD_W) + 1;
  localparam int NCH    = 2;
  localparam int EXT_BIT = HALF_W - 1;
  localparam int EN_BIT  = HALF_W - 2;
  localparam int POS_LSB = CODE_W;
  localparam int BASE_W  = 8;
  localparam int EXT_ADD = 16;

  typedef struct packed {
    logic [NCH-1:0] txLoad;
    logic [NCH-1:0] txShift;
    logic [NCH-1:0] txLast;
    logic [NCH-1:0] rxFirst;
    logic [NCH-1:0] rxShift;
    logic [NCH-1:0] rxDone;
    logic           txPopNow;
    logic           txUseHeld;
    logic           txPacked;
    logic           rxPushNow;
    logic           rxPacked;
    logic           rxLowUsed;
    logic [NCH-1:0][CNT_W-1:0] txWidth;
  } strobes_t;

  function automatic logic [CNT_W-1:0] chanWidth(input logic ext, input logic [CODE_W-1:0] code);
    logic [CNT_W:0] raw;
    raw = (CNT_W+1)'(BASE_W) + (CNT_W+1)'(code) + (ext ? (CNT_W+1)'(EXT_ADD) : '0);
    if (raw > (CNT_W+1)'(WORD_W)) return CNT_W'(WORD_W);
    return raw[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/slot_timer.sv
module slot_timer
  import serdes_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [POS_W-1:0]  bitPos,
  input  logic [HALF_W-1:0] field,
  output logic              enabled,
  output logic              start,
  output logic              step,
  output logic              last
);
  logic [CNT_W-1:0] width;
  logic [CNT_W-1:0] remain;
  logic [POS_W-1:0] startPos;

  assign enabled  = field[EN_BIT];
  assign startPos = field[POS_LSB +: POS_W];
  assign width    = chanWidth(field[EXT_BIT], field[CODE_W-1:0]);

  assign start = tick && enabled && (bitPos == startPos);
  assign step  = tick && !start && (remain != '0);
  assign last  = step && (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
    end else if (start) begin
      remain <= width - CNT_W'(1);
    end else if (step) begin
      remain <= remain - CNT_W'(1);
    end
  end
endmodule

// File: rtl/serdes_ctrl.sv
module serdes_ctrl
  import serdes_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [POS_W-1:0]  bitPos,
  input  logic [WORD_W-1:0] txCfg,
  input  logic [WORD_W-1:0] rxCfg,
  input  logic              txPacked,
  input  logic              rxPacked,
  output strobes_t          stb
);
  logic [NCH-1:0] txEn, txStart, txStep, txEnd;
  logic [NCH-1:0] rxEn, rxStart, rxStep, rxEnd;
  logic [NCH-1:0][CNT_W-1:0] txW;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    localparam int TOP = WORD_W - 1 - c * HALF_W;
    logic [HALF_W-1:0] txField, rxField;
    assign txField = txCfg[TOP -: HALF_W];
    assign rxField = rxCfg[TOP -: HALF_W];
    assign txW[c]  = chanWidth(txField[EXT_BIT], txField[CODE_W-1:0]);

    slot_timer u_txTimer (
      .clk(clk), .rstN(rstN), .tick(tick), .bitPos(bitPos), .field(txField),
      .enabled(txEn[c]), .start(txStart[c]), .step(txStep[c]), .last(txEnd[c])
    );
    slot_timer u_rxTimer (
      .clk(clk), .rstN(rstN), .tick(tick), .bitPos(bitPos), .field(rxField),
      .enabled(rxEn[c]), .start(rxStart[c]), .step(rxStep[c]), .last(rxEnd[c])
    );
  end

  always_comb begin
    stb           = '0;
    stb.txLoad    = txStart;
    stb.txShift   = txStep;
    stb.txLast    = txEnd;
    stb.rxFirst   = rxStart;
    stb.rxShift   = rxStep;
    stb.rxDone    = rxEnd;
    stb.txWidth   = txW;
    stb.txPacked  = txPacked;
    stb.rxPacked  = rxPacked;
    stb.txUseHeld = txPacked && txEn[0];
    stb.txPopNow  = txStart[0] || (txStart[1] && !(txPacked && txEn[0]));
    stb.rxLowUsed = rxPacked && rxEn[0];
    stb.rxPushNow = rxEnd[1] || (rxEnd[0] && !(rxPacked && rxEn[1]));
  end
endmodule

// File: rtl/serdes_datapath.sv
module serdes_datapath
  import serdes_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  strobes_t          stb,
  input  logic [WORD_W-1:0] txWord,
  input  logic              txValid,
  input  logic              rxIn,
  input  logic              rxFull,
  output logic              txPop,
  output logic              txUnderrun,
  output logic              txOut,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxPush,
  output logic              rxOverrun
);
  logic [WORD_W-1:0] fetched;
  logic [HALF_W-1:0] heldHi, loHeld;
  logic [NCH-1:0][WORD_W-1:0] samp, full;
  logic [NCH-1:0] drive;
  logic [WORD_W-1:0] pushData;

  assign fetched = txValid ? txWord : '0;
  assign samp[0] = stb.txPacked ? {{HALF_W{1'b0}}, fetched[HALF_W-1:0]} : fetched;
  assign samp[1] = stb.txUseHeld ? {{HALF_W{1'b0}}, heldHi}
                 : stb.txPacked  ? {{HALF_W{1'b0}}, fetched[WORD_W-1:HALF_W]} : fetched;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    logic [WORD_W-1:0] shReg, loadVal;
    logic [WORD_W-2:0] acc;
    logic bitNow;

    assign loadVal  = samp[c] << ((CNT_W+1)'(WORD_W) - {1'b0, stb.txWidth[c]});
    assign bitNow   = stb.txLoad[c] ? loadVal[WORD_W-1] : shReg[WORD_W-1];
    assign drive[c] = (stb.txLoad[c] || stb.txShift[c]) && bitNow;
    assign full[c]  = {acc, rxIn};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shReg <= '0;
        acc   <= '0;
      end else begin
        if (stb.txLoad[c])       shReg <= loadVal << 1;
        else if (stb.txLast[c])  shReg <= '0;
        else if (stb.txShift[c]) shReg <= shReg << 1;
        if (stb.rxFirst[c])      acc <= {{(WORD_W-2){1'b0}}, rxIn};
        else if (stb.rxShift[c]) acc <= full[c][WORD_W-2:0];
      end
    end
  end

  always_comb begin
    if (stb.rxPacked) begin
      if (stb.rxDone[1])
        pushData = {full[1][HALF_W-1:0], stb.rxLowUsed ? loHeld : {HALF_W{1'b0}}};
      else
        pushData = {{HALF_W{1'b0}}, full[0][HALF_W-1:0]};
    end else begin
      pushData = stb.rxDone[0] ? full[0] : full[1];
    end
  end

  assign txPop = stb.txPopNow && txValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txOut      <= 1'b0;
      txUnderrun <= 1'b0;
      heldHi     <= '0;
      loHeld     <= '0;
      rxWord     <= '0;
      rxPush     <= 1'b0;
      rxOverrun  <= 1'b0;
    end else begin
      if (tick) txOut <= |drive;
      txUnderrun <= stb.txPopNow && !txValid;
      if (stb.txLoad[0] && stb.txPacked) heldHi <= fetched[WORD_W-1:HALF_W];
      if (stb.rxDone[0]) loHeld <= full[0][HALF_W-1:0];
      if (stb.rxPushNow) rxWord <= pushData;
      rxPush    <= stb.rxPushNow && !rxFull;
      rxOverrun <= stb.rxPushNow && rxFull;
    end
  end
endmodule

// File: rtl/dual_slot_serdes.sv
module dual_slot_serdes
  import serdes_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic [POS_W-1:0]  bitPos,
  input  logic [WORD_W-1:0] txCfg,
  input  logic [WORD_W-1:0] rxCfg,
  input  logic              txPacked,
  input  logic              rxPacked,
  input  logic [WORD_W-1:0] txWord,
  input  logic              txValid,
  output logic              txPop,
  output logic              txUnderrun,
  output logic              txOut,
  input  logic              rxIn,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxPush,
  input  logic              rxFull,
  output logic              rxOverrun
);
  strobes_t stb;

  serdes_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(bitTick), .bitPos(bitPos),
    .txCfg(txCfg), .rxCfg(rxCfg), .txPacked(txPacked), .rxPacked(rxPacked),
    .stb(stb)
  );

  serdes_datapath u_dp (
    .clk(clk), .rstN(rstN), .tick(bitTick), .stb(stb),
    .txWord(txWord), .txValid(txValid), .rxIn(rxIn), .rxFull(rxFull),
    .txPop(txPop), .txUnderrun(txUnderrun), .txOut(txOut),
    .rxWord(rxWord), .rxPush(rxPush), .rxOverrun(rxOverrun)
  );
endmodule

// File: rtl/serdes_checker.sv
module serdes_checker (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic txPop,
  input logic txValid,
  input logic txUnderrun,
  input logic txOut,
  input logic rxPush,
  input logic rxFull,
  input logic rxOverrun
);
  assert_pop_with_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> (txValid && bitTick));

  assert_tx_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(bitTick) |-> $stable(txOut));

  assert_push_room_R11: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> !$past(rxFull));

  assert_push_or_drop_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(rxPush && rxOverrun));

  assert_events_follow_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush || rxOverrun || txUnderrun) |-> $past(bitTick));

  assert_underrun_no_pop_R8: assert property (@(posedge clk) disable iff (!rstN)
    txUnderrun |-> !$past(txPop));
endmodule

bind dual_slot_serdes serdes_checker u_checker (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .txPop(txPop), .txValid(txValid),
  .txUnderrun(txUnderrun), .txOut(txOut), .rxPush(rxPush), .rxFull(rxFull),
  .rxOverrun(rxOverrun)
);

// File: tb/dual_slot_serdes_bench.sv
`timescale 1ns/1ps
module dual_slot_serdes_bench;
  localparam int FRAME = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0;
  logic [9:0] bitPos = '0;
  logic [31:0] txCfg = '0, rxCfg = '0;
  logic txPacked = 1'b0, rxPacked = 1'b0;
  logic [31:0] txWord = '0;
  logic txValid = 1'b0;
  logic rxIn = 1'b0;
  logic rxFull = 1'b0;
  logic txPop, txUnderrun, txOut, rxPush, rxOverrun;
  logic [31:0] rxWord;

  always #2.5 clk = ~clk;

  dual_slot_serdes u_dual_slot_serdes (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .bitPos(bitPos),
    .txCfg(txCfg), .rxCfg(rxCfg), .txPacked(txPacked), .rxPacked(rxPacked),
    .txWord(txWord), .txValid(txValid), .txPop(txPop), .txUnderrun(txUnderrun),
    .txOut(txOut), .rxIn(rxIn), .rxWord(rxWord), .rxPush(rxPush),
    .rxFull(rxFull), .rxOverrun(rxOverrun)
  );

  int nChecks = 0, nFail = 0;
  int popCount = 0, udrCount = 0, ovrCount = 0;
  bit running = 1'b0, finished = 1'b0;
  string curTag = "R4";
  logic        expTx[$];
  logic [31:0] expRx[$];
  logic [31:0] txFifo[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic refreshFifo();
    txValid = (txFifo.size() != 0);
    txWord  = (txFifo.size() != 0) ? txFifo[0] : 32'h0;
  endtask

  function automatic logic [15:0] mk(input bit en, input bit ext, input int code, input int pos);
    logic [15:0] h;
    h = {ext, en, 10'(pos), 4'(code)};
    return h;
  endfunction

  function automatic int widthOf(input logic [15:0] h);
    int w;
    w = 8 + int'(h[3:0]) + (h[15] ? 16 : 0);
    return (w > 32) ? 32 : w;
  endfunction

  // scoreboard monitor: samples 1 ns after the edge that registered a strobe cycle
  always @(posedge clk) begin
    #1;
    if (rstN && running) begin
      if (bitTick) begin
        logic e;
        e = 1'b0;
        if (expTx.size() != 0) e = expTx.pop_front();
        else check(1'b0, curTag, "unexpected tx bit", {31'b0, txOut}, 32'h0);
        check(txOut === e, curTag, $sformatf("txOut at bit %0d", bitPos), {31'b0, txOut}, {31'b0, e});
      end
      if (txPop) begin
        popCount++;
        if (txFifo.size() != 0) void'(txFifo.pop_front());
        refreshFifo();
      end
      if (rxPush) begin
        logic [31:0] e;
        e = 32'hDEAD_BEEF;
        if (expRx.size() != 0) e = expRx.pop_front();
        check(rxWord === e, curTag, "rxWord", rxWord, e);
      end
      if (txUnderrun) udrCount++;
      if (rxOverrun) ovrCount++;
    end
  end

  task automatic runFrame(input string tag, input logic [31:0] tcfg, input logic [31:0] rcfg,
                          input bit tp, input bit rp, input int avail, input bit full);
    logic [31:0] words[4];
    logic [31:0] s[2];
    logic [31:0] v[2];
    logic [15:0] hi;
    logic rxBits[FRAME];
    int idx, expPops, expUdr, expOvr, nPush;
    logic [15:0] th[2];
    logic [15:0] rh[2];
    th[0] = tcfg[31:16]; th[1] = tcfg[15:0];
    rh[0] = rcfg[31:16]; rh[1] = rcfg[15:0];
    @(negedge clk);
    curTag = tag;
    txCfg = tcfg; rxCfg = rcfg; txPacked = tp; rxPacked = rp; rxFull = full;
    popCount = 0; udrCount = 0; ovrCount = 0;
    txFifo.delete();
    for (int i = 0; i < 4; i++) begin
      words[i] = $urandom();
      if (i < avail) txFifo.push_back(words[i]);
    end
    refreshFifo();
    // expected transmit samples, channel 1 window precedes channel 2
    idx = 0; expPops = 0; expUdr = 0; hi = '0;
    s[0] = '0; s[1] = '0;
    for (int c = 0; c < 2; c++) begin
      if (th[c][14]) begin
        if (c == 1 && tp && th[0][14]) begin
          s[1] = {16'h0, hi};
        end else begin
          logic [31:0] f;
          f = (idx < avail) ? words[idx] : 32'h0;
          if (idx < avail) expPops++; else expUdr++;
          idx++;
          if (tp) s[c] = (c == 0) ? {16'h0, f[15:0]} : {16'h0, f[31:16]};
          else    s[c] = f;
          if (c == 0) hi = f[31:16];
        end
      end
    end
    for (int p = 0; p < FRAME; p++) begin
      logic b;
      b = 1'b0;
      for (int c = 0; c < 2; c++) begin
        int pos, w;
        pos = int'(th[c][13:4]);
        w = widthOf(th[c]);
        if (th[c][14] && p >= pos && p < pos + w) b = b | s[c][w - 1 - (p - pos)];
      end
      expTx.push_back(b);
    end
    // expected receive words
    for (int p = 0; p < FRAME; p++) rxBits[p] = 1'($urandom());
    for (int c = 0; c < 2; c++) begin
      int pos, w;
      pos = int'(rh[c][13:4]);
      w = widthOf(rh[c]);
      v[c] = '0;
      for (int k = 0; k < w; k++) v[c] = {v[c][30:0], rxBits[pos + k]};
    end
    nPush = 0;
    if (rp) begin
      if (rh[1][14]) begin
        nPush = 1;
        if (!full) expRx.push_back({v[1][15:0], rh[0][14] ? v[0][15:0] : 16'h0});
      end else if (rh[0][14]) begin
        nPush = 1;
        if (!full) expRx.push_back({16'h0, v[0][15:0]});
      end
    end else begin
      for (int c = 0; c < 2; c++) if (rh[c][14]) begin
        nPush++;
        if (!full) expRx.push_back(v[c]);
      end
    end
    expOvr = full ? nPush : 0;
    running = 1'b1;
    for (int p = 0; p < FRAME; p++) begin
      bitTick = 1'b1; bitPos = 10'(p); rxIn = rxBits[p];
      @(negedge clk);
      bitTick = 1'b0;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check(expTx.size() == 0, tag, "tx bits left unchecked", expTx.size(), 0);
    check(expRx.size() == 0, tag, "rx words not pushed", expRx.size(), 0);
    check(popCount == expPops, "R6", "pop count", popCount, expPops);
    check(udrCount == expUdr, "R8", "underrun count", udrCount, expUdr);
    check(ovrCount == expOvr, "R11", "overrun count", ovrCount, expOvr);
    expTx.delete(); expRx.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(txOut === 1'b0, "R1", "txOut in reset", {31'b0, txOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(txOut === 1'b0, "R1", "txOut after reset", {31'b0, txOut}, 0);
    check(rxPush === 1'b0, "R1", "rxPush after reset", {31'b0, rxPush}, 0);
    check(txPop === 1'b0, "R1", "txPop after reset", {31'b0, txPop}, 0);
    check(txUnderrun === 1'b0 && rxOverrun === 1'b0, "R1", "error strobes after reset",
          {30'b0, txUnderrun, rxOverrun}, 0);
    // 16-bit channels at bits 1 and 33
    runFrame("R4", {mk(1,0,8,1), mk(1,0,8,33)}, {mk(1,0,8,1), mk(1,0,8,33)}, 0, 0, 2, 0);
    // 24-bit channel 1 and clamped 32-bit channel 2
    runFrame("R3", {mk(1,1,0,1), mk(1,1,15,32)}, {mk(1,1,0,1), mk(1,1,15,32)}, 0, 0, 2, 0);
    // distinct layouts per direction, capture from bit 0
    runFrame("R2/R9", {mk(1,0,4,3), mk(1,0,12,40)}, {mk(1,0,12,0), mk(1,0,2,30)}, 0, 0, 2, 0);
    // packing in both directions
    runFrame("R7/R10", {mk(1,0,8,0), mk(1,0,8,32)}, {mk(1,0,8,0), mk(1,0,8,32)}, 1, 1, 1, 0);
    // packing with one channel disabled
    runFrame("R7/R10", {mk(0,0,8,0), mk(1,0,8,32)}, {mk(1,0,8,4), mk(0,0,8,32)}, 1, 1, 1, 0);
    // empty transmit FIFO and full receive FIFO
    runFrame("R8/R11", {mk(1,0,8,1), mk(1,0,8,33)}, {mk(1,0,8,1), mk(1,0,8,33)}, 0, 0, 0, 1);
    // channel 2 disabled: zeros outside channel 1 window
    runFrame("R12/R5", {mk(1,0,0,5), mk(0,0,8,33)}, {mk(1,0,0,5), mk(0,0,8,33)}, 0, 0, 2, 0);
    // packed underrun with full receive FIFO
    runFrame("R8/R11", {mk(1,0,8,0), mk(1,0,8,32)}, {mk(1,0,8,0), mk(1,0,8,32)}, 1, 1, 0, 1);
    running = 1'b0;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "R1", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule